// File: doc/BRIEF.md
# Dual-Port RAM with Address Stall

A synchronous memory with one port that only writes and one port that only reads. Each port captures its address in a register on every rising clock edge. Each port also has its own stall input. While a stall is high, that port's address register keeps the value it already holds, and the new address on the input is not loaded. A transaction can therefore keep working on an earlier address while the source of addresses moves on. This suits a cache-style arrangement in which a fill engine writes lines and a lookup path reads them.

The write enable and the write data are registered on the same edge as the write address. The store into the array happens on the following edge, at whatever address the write register holds at that moment. The read port registers its address, and the read data register samples the array one edge later.

When both stall inputs are held low, the block behaves as an ordinary RAM with registered addresses. The depth may be smaller than the address space. Addresses at or above the depth are treated as unmapped.

Top module: `stall_dpram`

## Requirements
- R1: A synchronous reset clears both address registers to 0 and cancels any registered write. The reset takes priority over the stall inputs and does not change the array contents. After reset is released with the read stall held high, rdData shows the word at address 0.
- R2: With wrStall low, the write address register loads wrAddr on every rising edge. A write presented with wrEn=1 at edge N is stored at edge N+1, using the data sampled at edge N.
- R3: With rdStall low, the read address register loads rdAddr at edge N. rdData holds the word at that address after edge N+1.
- R4: While rdStall is high, the read address is held. rdData keeps following the current contents at the held address, and that includes words written during the stall.
- R5: While wrStall is high, the write address is held. Every write issued during the stall lands at the held address, and the other locations stay unchanged.
- R6: If a write is stored at the same edge on which the read data register samples that same address, rdData returns the old word (read-before-write). The new word appears one edge later.
- R7: An address at or above DEPTH (12 by default) is unmapped. A write to it changes no location, and a read from it returns all zeros.
- R8: The two stall inputs are independent. Stalling one port does not freeze or alter the address of the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request, registered with the write data |
| wrStall | input | 1 | Holds the write address register when high |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdStall | input | 1 | Holds the read address register when high |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Registered read data |

## Verification
The bench goes after held addresses: writes and reads issued during a stall, and mixed stalls with one port frozen while the other moves. A design that loaded the address during a stall would scatter writes, or return data from the new address. It drives same-address collisions, where a write-first array would return the new word one cycle early. It also resets with the read stall high: a design that gave stall priority over reset would read from a stale address after the reset, and a design that cleared the array would lose stored words. Unmapped addresses 12 to 15 are also targeted, where a design without the range check would alias into mapped words or return garbage in place of zeros.

// File: rtl/stall_dpram_pkg.sv
package stall_dpram_pkg;
  typedef struct packed {
    logic wrFire;     // store registered write data this edge
    logic rdInRange;  // registered read address is mapped
  } ctrl_t;
endpackage

// File: rtl/stall_dpram_addr_hold.sv
module stall_dpram_addr_hold #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrQ
);
  logic [ADDR_W-1:0] addrNext;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bitMux
    assign addrNext[b] = stall ? addrQ[b] : addrIn[b];
  end

  always_ff @(posedge clk) begin
    if (rst) addrQ <= '0;
    else     addrQ <= addrNext;
  end

  // R1
  rst_clears_chk: assert property (@(posedge clk) rst |=> addrQ == '0);
  // R4 R5
  stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(addrQ));
  // R2 R3
  load_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> addrQ == $past(addrIn));
endmodule

// File: rtl/stall_dpram_ctrl.sv
module stall_dpram_ctrl
  import stall_dpram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrStall,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdStall,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddrQ,
  output logic [ADDR_W-1:0] rdAddrQ,
  output ctrl_t             ctrl
);
  localparam logic [ADDR_W:0] LIMIT = DEPTH[ADDR_W:0];

  logic wrEnQ;

  stall_dpram_addr_hold #(.ADDR_W(ADDR_W)) wrHold_i (
    .clk(clk), .rst(rst), .stall(wrStall), .addrIn(wrAddr), .addrQ(wrAddrQ));

  stall_dpram_addr_hold #(.ADDR_W(ADDR_W)) rdHold_i (
    .clk(clk), .rst(rst), .stall(rdStall), .addrIn(rdAddr), .addrQ(rdAddrQ));

  always_ff @(posedge clk) begin
    if (rst) wrEnQ <= 1'b0;
    else     wrEnQ <= wrEn;
  end

  always_comb begin
    ctrl.wrFire    = wrEnQ && ({1'b0, wrAddrQ} < LIMIT);
    ctrl.rdInRange = {1'b0, rdAddrQ} < LIMIT;
  end

  // R1
  no_write_after_reset_chk: assert property (@(posedge clk)
    rst |=> !ctrl.wrFire);
  // R8
  rd_free_of_wr_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (wrStall && !rdStall) |=> rdAddrQ == $past(rdAddr));
endmodule

// File: rtl/stall_dpram_dp.sv
module stall_dpram_dp
  import stall_dpram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] wrAddrQ,
  input  logic [ADDR_W-1:0] rdAddrQ,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wrDataQ;

  always_ff @(posedge clk) wrDataQ <= wrData;

  always_ff @(posedge clk) begin
    if (ctrl.wrFire) mem[wrAddrQ] <= wrDataQ;
  end

  always_ff @(posedge clk) begin
    if (ctrl.rdInRange) rdData <= mem[rdAddrQ];
    else                rdData <= '0;
  end

  // R2
  store_lands_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.wrFire |=> mem[$past(wrAddrQ)] == $past(wrDataQ));
  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.rdInRange |=> rdData == '0);
endmodule

// File: rtl/stall_dpram.sv
module stall_dpram
  import stall_dpram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrStall,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStall,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [ADDR_W-1:0] rdAddrQ;

  stall_dpram_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrStall(wrStall), .wrAddr(wrAddr),
    .rdStall(rdStall), .rdAddr(rdAddr), .wrAddrQ(wrAddrQ), .rdAddrQ(rdAddrQ),
    .ctrl(ctrl));

  stall_dpram_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .wrAddrQ(wrAddrQ), .rdAddrQ(rdAddrQ),
    .wrData(wrData), .rdData(rdData));
endmodule

// File: tb/stall_dpram_tb_top.sv
module stall_dpram_tb_top;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, wrStall = 1'b0, rdStall = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [DW-1:0] mMem [DEPTH];
  bit            mKnown [DEPTH];
  logic [AW-1:0] mWrA = '0, mRdA = '0;
  logic [DW-1:0] mWrD = '0, mRd = '0;
  bit            mWrEn = 0, mRdKnown = 0, lastWrStall = 0;

  stall_dpram #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrStall(wrStall), .wrAddr(wrAddr),
    .wrData(wrData), .rdStall(rdStall), .rdAddr(rdAddr), .rdData(rdData));

  always #5 clk = ~clk;

  function automatic bit mapped(input logic [AW-1:0] a);
    return int'(a) < DEPTH;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // one clock: update the reference at the edge, compare at the falling edge
  task automatic step(input string tagIn);
    string tag;
    logic [DW-1:0] nRd;
    bit nKnown;
    tag = tagIn;
    @(posedge clk);
    if (tag == "") begin
      if (!mapped(mRdA)) tag = "R7";
      else if (mWrEn && mapped(mWrA) && mWrA == mRdA) tag = "R6";
      else if (rdStall) tag = "R4";
      else if (lastWrStall) tag = "R5";
      else tag = "R3";
    end
    if (mapped(mRdA)) begin nRd = mMem[mRdA]; nKnown = mKnown[mRdA]; end
    else begin nRd = '0; nKnown = 1; end
    if (mWrEn && mapped(mWrA)) begin mMem[mWrA] = mWrD; mKnown[mWrA] = 1; end
    lastWrStall = wrStall;
    mWrEn = rst ? 0 : wrEn;
    mWrD  = wrData;
    mWrA  = rst ? '0 : (wrStall ? mWrA : wrAddr);
    mRdA  = rst ? '0 : (rdStall ? mRdA : rdAddr);
    mRd = nRd; mRdKnown = nKnown;
    @(negedge clk);
    if (mRdKnown && !rst) begin
      checks++;
      if (rdData !== mRd) begin
        fails++;
        $display("FAIL %s: rdData actual %h expected %h", tag, rdData, mRd);
      end
    end
  endtask

  task automatic setIn(input bit we, input bit ws, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input bit rs,
                       input logic [AW-1:0] ra);
    wrEn = we; wrStall = ws; wrAddr = wa; wrData = wd; rdStall = rs; rdAddr = ra;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) begin mKnown[i] = 0; mMem[i] = '0; end
    @(negedge clk); step("R1"); step("R1");
    rst = 1'b0;

    // R2: plain writes, then reads of them (R3)
    setIn(1, 0, 4'd0, 8'hA5, 0, 4'd0); step("R2");
    setIn(1, 0, 4'd5, 8'h3C, 0, 4'd0); step("R2");
    setIn(0, 0, 4'd0, 8'h00, 0, 4'd5); step("R2");
    step("R3"); step("R3");

    // R1: reset with read stall high -> address 0, array kept
    setIn(1, 0, 4'd5, 8'hFF, 1, 4'd5); rst = 1'b1; step("R1");
    rst = 1'b0; wrEn = 0; step("R1"); step("R1"); step("R1");
    rdStall = 0; step("R1"); step("R1");

    // R6: collision, old then new
    setIn(1, 0, 4'd7, 8'h11, 0, 4'd7); step("R6");
    wrEn = 0; step("R6"); step("R6");
    setIn(1, 0, 4'd7, 8'h22, 0, 4'd7); step("R6");
    wrEn = 0; step("R6"); step("R6"); step("R6");

    // R4: read stalled at 7, writes to 7 show through
    setIn(0, 0, 4'd2, 8'h00, 1, 4'd3); step("R4");
    setIn(1, 0, 4'd7, 8'h77, 1, 4'd9); step("R4");
    wrEn = 0; step("R4"); step("R4"); step("R4");

    // R5: write stalled at 3, burst lands there; R8 read port keeps moving
    setIn(1, 0, 4'd3, 8'h30, 0, 4'd0); step("R5");
    setIn(1, 1, 4'd8, 8'h31, 0, 4'd3); step("R8");
    setIn(1, 1, 4'd9, 8'h32, 0, 4'd8); step("R8");
    setIn(0, 1, 4'd1, 8'h00, 0, 4'd3); step("R8");
    setIn(0, 0, 4'd1, 8'h00, 0, 4'd3); step("R5"); step("R5"); step("R5");

    // R7: unmapped addresses
    setIn(1, 0, 4'd12, 8'hEE, 0, 4'd14); step("R7");
    setIn(1, 0, 4'd15, 8'hDD, 0, 4'd13); step("R7");
    setIn(0, 0, 4'd0, 8'h00, 0, 4'd0); step("R7"); step("R7");

    // fill so random reads are checkable
    for (int a = 0; a < DEPTH; a++) begin
      setIn(1, 0, AW'(a), DW'($urandom), 0, 4'd0); step("R2");
    end
    wrEn = 0; step("R2");

    for (int n = 0; n < 3000; n++) begin
      setIn(bit'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
            AW'($urandom), DW'($urandom), ($urandom_range(0, 3) == 0),
            AW'($urandom));
      step("");
    end
    setIn(0, 0, 4'd0, 8'h00, 0, 4'd0); step(""); step("");
    finishRun();
  end
endmodule